// File: doc/BRIEF.md
# Conversion Timing Sequencer for a Two-Channel Sensor Converter

This block is the control core of a converter with a capacitive channel and a voltage/temperature channel. It reads the operating-mode field and the per-channel setup fields held in configuration registers, and turns them into conversion timing. A timebase input supplies one pulse every 0.1 ms. The block counts these pulses for the selected conversion length, flags the end of each conversion, and drives the excitation enable for the capacitive sensor.

In continuous mode it runs conversions without a break. When both channels are enabled it alternates between them, starting with the capacitive channel. Single-conversion mode and the two calibration modes stop by themselves. When they finish, the block pulses a write-back strobe so that the register holding the mode field returns to idle. An offset calibration loads the supplied calibration result into a 16-bit offset register. The modulator and the filter arithmetic are outside this block.

Top module: `conv_sequencer`

## Requirements
- R1: The mode field `mode` is decoded as 001 continuous, 010 single, 101 capacitive offset calibration and 110 gain calibration. The codes 000 (idle), 011 (power-down), 100 and 111 start no conversion.
- R2: With `cap_chop`=0, a capacitive conversion lasts 110, 119, 200, 380, 620, 770, 920 or 1096 ticks for `cap_fs` = 0 to 7.
- R3: With `cap_chop`=1, a capacitive conversion lasts 201, 220, 381, 741, 1221, 1521, 1821 or 2173 ticks for `cap_fs` = 0 to 7.
- R4: A voltage/temperature conversion lasts 201, 321, 621 or 1221 ticks for `vt_fs` = 0 to 3.
- R5: With `clk_half`=1, every conversion length on both channels is doubled.
- R6: A conversion begins on the clock edge where the sequencer starts it. Its done output (`cap_done`, `vt_done` or `cal_done`) is high for one cycle, after the edge at which the last tick of the conversion is counted. The next conversion starts one cycle later, and at most one done output is high in any cycle.
- R7: In continuous mode with both channels enabled, the conversions alternate cap, vt, cap and so on, starting with the capacitive channel. `active_vt` is 1 while a voltage/temperature conversion runs.
- R8: A channel converts only when its enable bit (`cap_en`, `vt_en`) is 1. Calibration uses the capacitive channel, so it needs `cap_en`.
- R9: Single mode converts the capacitive channel if it is enabled, then the voltage/temperature channel if it is enabled. `mode_clr` pulses together with the last done pulse. No further conversion starts while `mode` stays at 010.
- R10: A calibration runs for one capacitive conversion length and ends with `cal_done`, not `cap_done`, together with `mode_clr`. Offset calibration (101) loads `cal_result` into `offset_q`. Gain calibration leaves `offset_q` unchanged. `offset_q` resets to 0x8000.
- R11: `exc_en` is 1 during capacitive conversions. During voltage/temperature conversions it equals `exc_on`. It is 0 when no conversion runs.
- R12: A mode that does not run a conversion clears `conv_busy` on the next edge and discards the partial count. A restart counts the full length from zero.
- R13: The counter advances only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 0.1 ms timebase pulse |
| cap_en | input | 1 | Capacitive channel enable |
| cap_chop | input | 1 | Capacitive chopping on |
| cap_fs | input | 3 | Capacitive conversion-time select |
| vt_en | input | 1 | Voltage/temperature channel enable |
| vt_fs | input | 2 | Voltage/temperature conversion-time select |
| clk_half | input | 1 | Clock-control bit, doubles all conversion lengths |
| exc_on | input | 1 | Keep excitation on during voltage/temperature conversions |
| mode | input | 3 | Operating mode field |
| cal_result | input | 16 | Offset result to store at the end of an offset calibration |
| conv_busy | output | 1 | A conversion is in progress |
| active_vt | output | 1 | The running conversion is on the voltage/temperature channel |
| exc_en | output | 1 | Excitation enable |
| cap_done | output | 1 | Capacitive conversion finished (one cycle) |
| vt_done | output | 1 | Voltage/temperature conversion finished (one cycle) |
| cal_done | output | 1 | Calibration finished (one cycle) |
| mode_clr | output | 1 | Write-back strobe: set the mode field to 000 |
| offset_q | output | 16 | Capacitive offset register |

## Verification
The timing tables are tried at the low and high ends of each select, with and without chopping and clock halving. An off-by-one, a wrong table entry or a missed doubling therefore shows up as a done pulse in the wrong cycle. The mode patterns are continuous operation with one channel and with both channels, single operation with one channel and with both, the two calibrations, power-down in the middle of a conversion, and the undefined codes. Together they separate alternation order, self-termination and discarding of a partial count. Runs with the tick held low and with channels disabled show that neither time nor a disabled channel produces a conversion.

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int BASE_W = 13,
  parameter logic [15:0] OFFSET_RST = 16'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        cap_en,
  input  logic        cap_chop,
  input  logic [2:0]  cap_fs,
  input  logic        vt_en,
  input  logic [1:0]  vt_fs,
  input  logic        clk_half,
  input  logic        exc_on,
  input  logic [2:0]  mode,
  input  logic [15:0] cal_result,
  output logic        conv_busy,
  output logic        active_vt,
  output logic        exc_en,
  output logic        cap_done,
  output logic        vt_done,
  output logic        cal_done,
  output logic        mode_clr,
  output logic [15:0] offset_q
);
  localparam int CNT_W = BASE_W + 1;

  function automatic logic [BASE_W-1:0] cap_ticks(input logic chop, input logic [2:0] fs);
    logic [BASE_W-1:0] t;
    if (!chop)
      case (fs)
        3'd0: t = BASE_W'(110);
        3'd1: t = BASE_W'(119);
        3'd2: t = BASE_W'(200);
        3'd3: t = BASE_W'(380);
        3'd4: t = BASE_W'(620);
        3'd5: t = BASE_W'(770);
        3'd6: t = BASE_W'(920);
        default: t = BASE_W'(1096);
      endcase
    else
      case (fs)
        3'd0: t = BASE_W'(201);
        3'd1: t = BASE_W'(220);
        3'd2: t = BASE_W'(381);
        3'd3: t = BASE_W'(741);
        3'd4: t = BASE_W'(1221);
        3'd5: t = BASE_W'(1521);
        3'd6: t = BASE_W'(1821);
        default: t = BASE_W'(2173);
      endcase
    return t;
  endfunction

  function automatic logic [BASE_W-1:0] vt_ticks(input logic [1:0] fs);
    logic [BASE_W-1:0] t;
    case (fs)
      2'd0: t = BASE_W'(201);
      2'd1: t = BASE_W'(321);
      2'd2: t = BASE_W'(621);
      default: t = BASE_W'(1221);
    endcase
    return t;
  endfunction

  logic             busy, ch, prev_cap, halt;
  logic [CNT_W-1:0] cnt;

  wire is_cont   = (mode == 3'b001);
  wire is_single = (mode == 3'b010);
  wire is_offcal = (mode == 3'b101);
  wire is_cal    = is_offcal || (mode == 3'b110);
  wire run       = is_cont || is_single || is_cal;

  wire [BASE_W-1:0] base = ch ? vt_ticks(vt_fs) : cap_ticks(cap_chop, cap_fs);
  wire [CNT_W-1:0]  len  = clk_half ? {base, 1'b0} : {1'b0, base};
  wire [CNT_W:0]    cnt_nx = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

  wire want_vt   = !is_cal && vt_en && (!cap_en || prev_cap);
  wire can_start = run && !busy && !halt && (is_cal ? cap_en : (cap_en || vt_en));
  wire last      = busy && tick && (cnt_nx >= {1'b0, len});
  wire finish    = last && (is_cal || (is_single && (ch || !vt_en)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ch       <= 1'b0;
      prev_cap <= 1'b0;
      halt     <= 1'b0;
      cnt      <= '0;
      cap_done <= 1'b0;
      vt_done  <= 1'b0;
      cal_done <= 1'b0;
      mode_clr <= 1'b0;
      offset_q <= OFFSET_RST;
    end else begin
      cap_done <= 1'b0;
      vt_done  <= 1'b0;
      cal_done <= 1'b0;
      mode_clr <= 1'b0;
      if (!run) begin
        busy     <= 1'b0;
        cnt      <= '0;
        prev_cap <= 1'b0;
        halt     <= 1'b0;
      end else if (can_start) begin
        busy <= 1'b1;
        ch   <= want_vt;
        cnt  <= '0;
      end else if (busy && tick) begin
        if (last) begin
          busy     <= 1'b0;
          cnt      <= '0;
          prev_cap <= !ch;
          if (is_cal) cal_done <= 1'b1;
          else if (ch) vt_done <= 1'b1;
          else cap_done <= 1'b1;
          if (finish) begin
            halt     <= 1'b1;
            mode_clr <= 1'b1;
          end
          if (is_offcal) offset_q <= cal_result;
        end else begin
          cnt <= cnt_nx[CNT_W-1:0];
        end
      end
    end
  end

  assign conv_busy = busy;
  assign active_vt = busy && ch;
  assign exc_en    = busy && (!ch || exc_on);

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_done, vt_done, cal_done})); // R6
  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done || vt_done || cal_done) |-> ($past(tick) && $past(busy))); // R13
  AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done || vt_done || cal_done) |-> $past(run)); // R1
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !conv_busy); // R12
  AST_CLR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |-> ((cap_done || vt_done || cal_done) && !conv_busy)); // R9
  AST_CAP_EXCITED: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> $past(exc_en)); // R11
  AST_VT_EXC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (vt_done && !$past(exc_on)) |-> !$past(exc_en)); // R11
  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |-> $stable(offset_q)); // R10
endmodule

// File: tb/sim_conv_sequencer.sv
module sim_conv_sequencer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick, cap_en, cap_chop, vt_en, clk_half, exc_on;
  logic [2:0] cap_fs, mode;
  logic [1:0] vt_fs;
  logic [15:0] cal_result;
  logic conv_busy, active_vt, exc_en, cap_done, vt_done, cal_done, mode_clr;
  logic [15:0] offset_q;

  conv_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cap_en(cap_en), .cap_chop(cap_chop),
    .cap_fs(cap_fs), .vt_en(vt_en), .vt_fs(vt_fs), .clk_half(clk_half),
    .exc_on(exc_on), .mode(mode), .cal_result(cal_result),
    .conv_busy(conv_busy), .active_vt(active_vt), .exc_en(exc_en),
    .cap_done(cap_done), .vt_done(vt_done), .cal_done(cal_done),
    .mode_clr(mode_clr), .offset_q(offset_q));

  typedef struct {
    int    kind;
    bit    clr;
    int    at;
    string req;
  } exp_t;

  exp_t sbq[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input int kind, input bit clr, input int at, input string req);
    exp_t e;
    e.kind = kind; e.clr = clr; e.at = at; e.req = req;
    sbq.push_back(e);
  endtask

  // monitor: kind 0 cap, 1 vt, 2 cal, 3 write-back alone
  always @(negedge clk) begin : monitor
    exp_t e;
    int k;
    if (rst_n && (cap_done || vt_done || cal_done || mode_clr)) begin
      k = cap_done ? 0 : vt_done ? 1 : cal_done ? 2 : 3;
      if (sbq.size() == 0) begin
        check(1'b0, "R6", "unexpected done event kind", k, -1);
      end else begin
        e = sbq.pop_front();
        check(k == e.kind, e.req, "done kind", k, e.kind);
        check(mode_clr == e.clr, e.req, "mode_clr with done", int'(mode_clr), int'(e.clr));
        check(cyc == e.at, e.req, "done cycle", cyc, e.at);
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_empty();
    while (sbq.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m, output int c0);
    @(negedge clk);
    mode = m;
    c0 = cyc;
  endtask

  task automatic go_idle();
    @(negedge clk);
    mode = 3'b000;
    @(negedge clk);
  endtask

  task automatic at_cycle(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    int c0;
    rst_n = 1'b0; tick = 1'b1; cap_en = 1'b0; cap_chop = 1'b0; cap_fs = 3'd0;
    vt_en = 1'b0; vt_fs = 2'd0; clk_half = 1'b0; exc_on = 1'b0; mode = 3'b000;
    cal_result = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(conv_busy == 1'b0, "R1", "reset busy", int'(conv_busy), 0);
    check(exc_en == 1'b0, "R11", "reset exc_en", int'(exc_en), 0);
    check(offset_q == 16'h8000, "R10", "reset offset", int'(offset_q), 32768);

    // R2 R6 continuous capacitive only, select 0
    cap_en = 1'b1;
    set_mode(3'b001, c0);
    push(0, 0, c0 + 111, "R2");
    push(0, 0, c0 + 222, "R6");
    push(0, 0, c0 + 333, "R6");
    wait_empty();
    go_idle();
    check(conv_busy == 1'b0, "R12", "busy after idle", int'(conv_busy), 0);

    // R13 tick held low
    @(negedge clk);
    tick = 1'b0;
    set_mode(3'b001, c0);
    repeat (200) @(negedge clk);
    check(conv_busy == 1'b1, "R13", "busy while tick low", int'(conv_busy), 1);
    tick = 1'b1;
    c0 = cyc;
    push(0, 0, c0 + 110, "R13");
    wait_empty();
    go_idle();

    // R12 power-down mid conversion, restart counts from zero
    set_mode(3'b001, c0);
    repeat (50) @(negedge clk);
    mode = 3'b011;
    @(negedge clk);
    check(conv_busy == 1'b0, "R12", "busy after power-down", int'(conv_busy), 0);
    check(exc_en == 1'b0, "R12", "exc after power-down", int'(exc_en), 0);
    repeat (20) @(negedge clk);
    check(conv_busy == 1'b0, "R1", "power-down starts nothing", int'(conv_busy), 0);
    set_mode(3'b001, c0);
    push(0, 0, c0 + 111, "R12");
    wait_empty();
    go_idle();

    // R5 R9 single capacitive, select 7 doubled, no restart afterwards
    cap_fs = 3'd7; clk_half = 1'b1;
    set_mode(3'b010, c0);
    push(0, 1, c0 + 1 + 2192, "R5");
    wait_empty();
    repeat (50) @(negedge clk);
    check(conv_busy == 1'b0, "R9", "no restart in single", int'(conv_busy), 0);
    go_idle();

    // R3 single capacitive, chop on, select 7
    clk_half = 1'b0; cap_chop = 1'b1;
    set_mode(3'b010, c0);
    push(0, 1, c0 + 2174, "R3");
    wait_empty();
    go_idle();

    // R9 R4 single both channels: cap then vt select 3
    cap_chop = 1'b0; cap_fs = 3'd0; vt_en = 1'b1; vt_fs = 2'd3;
    set_mode(3'b010, c0);
    push(0, 0, c0 + 111, "R9");
    push(1, 1, c0 + 1333, "R4");
    wait_empty();
    go_idle();

    // R7 R11 continuous both: chop on select 1, vt select 0, exc_on 0
    cap_chop = 1'b1; cap_fs = 3'd1; vt_fs = 2'd0; exc_on = 1'b0;
    set_mode(3'b001, c0);
    push(0, 0, c0 + 221, "R3");
    push(1, 0, c0 + 423, "R7");
    push(0, 0, c0 + 644, "R7");
    at_cycle(c0 + 100);
    check(active_vt == 1'b0, "R7", "first channel is cap", int'(active_vt), 0);
    check(exc_en == 1'b1, "R11", "exc on during cap", int'(exc_en), 1);
    at_cycle(c0 + 300);
    check(active_vt == 1'b1, "R7", "second channel is vt", int'(active_vt), 1);
    check(exc_en == 1'b0, "R11", "exc off during vt", int'(exc_en), 0);
    wait_empty();
    go_idle();

    // R4 R5 R11 continuous vt only, select 1 doubled, exc_on 1
    cap_en = 1'b0; vt_fs = 2'd1; clk_half = 1'b1; exc_on = 1'b1;
    set_mode(3'b001, c0);
    push(1, 0, c0 + 643, "R4");
    at_cycle(c0 + 300);
    check(exc_en == 1'b1, "R11", "exc kept on during vt", int'(exc_en), 1);
    wait_empty();
    go_idle();

    // R10 offset calibration then gain calibration
    clk_half = 1'b0; exc_on = 1'b0; cap_en = 1'b1; cap_chop = 1'b0; cap_fs = 3'd0;
    cal_result = 16'h1234;
    set_mode(3'b101, c0);
    push(2, 1, c0 + 111, "R10");
    wait_empty();
    check(offset_q == 16'h1234, "R10", "offset loaded", int'(offset_q), 4660);
    go_idle();
    cal_result = 16'h5555;
    set_mode(3'b110, c0);
    push(2, 1, c0 + 111, "R10");
    wait_empty();
    check(offset_q == 16'h1234, "R10", "gain cal keeps offset", int'(offset_q), 4660);
    go_idle();

    // R8 enable gating
    cap_en = 1'b0; vt_en = 1'b0;
    set_mode(3'b001, c0);
    repeat (300) @(negedge clk);
    check(conv_busy == 1'b0, "R8", "no channel enabled", int'(conv_busy), 0);
    go_idle();
    vt_en = 1'b1;
    set_mode(3'b101, c0);
    repeat (300) @(negedge clk);
    check(conv_busy == 1'b0, "R8", "calibration without cap_en", int'(conv_busy), 0);
    go_idle();

    // R1 undefined codes
    cap_en = 1'b1;
    set_mode(3'b100, c0);
    repeat (20) @(negedge clk);
    check(conv_busy == 1'b0, "R1", "code 100 idle", int'(conv_busy), 0);
    set_mode(3'b111, c0);
    repeat (20) @(negedge clk);
    check(conv_busy == 1'b0, "R1", "code 111 idle", int'(conv_busy), 0);
    go_idle();

    repeat (5) @(negedge clk);
    check(sbq.size() == 0, "R6", "pending expected events", sbq.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule